// File: doc/BRIEF.md
# Dual-Modulus Fractional Feedback Divider

This block sits in the feedback path of a fractional-N frequency synthesizer. It counts edges of a clock derived from the VCO and emits one single-clock pulse per output cycle toward the phase detector. Each output cycle lasts either N or N+1 input clocks. A 2-bit phase accumulator makes the choice, so that over time the mean division ratio is N + k/4, where k is a 2-bit fraction numerator.

The core is a two-state machine driving a down-counter. In `ST_COUNT` the counter decrements. The `count_done` transition (counter at zero) moves to `ST_TERM`, which is the single pulse cycle. The `reload` transition leaves `ST_TERM` for `ST_COUNT` on the next edge. That edge is the output-cycle boundary: the integer ratio and the fraction are sampled there, the accumulator steps, and the counter is reloaded with the length of the next cycle minus two. The `reset` transition forces `ST_COUNT` from either state. A ratio below 4 is raised to 4 before use. An output flag shows whether the running cycle is the long one.

Top module: `frac_fb_divider`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator is cleared and the counter is loaded for a cycle of N. `div_pulse` and `long_cyc` read 0 after such an edge. The first pulse is high after the (N-1)th rising edge with `rst` low.
- R2: `div_pulse` is never high for two consecutive clock cycles.
- R3: The number of rising edges from one pulse to the next is the effective N when `long_cyc` is 0 during the closing pulse, and the effective N plus 1 when it is 1.
- R4: At each boundary the accumulator adds k modulo 4. A carry out makes the next cycle long, so with a fixed k exactly k cycles in any 4 consecutive cycles are long.
- R5: With k = 0 sampled at a boundary, the following cycle is never long.
- R6: `ratio_int` and `frac_num` are sampled only at the rising edge that ends the pulse cycle. Values held at any other edge have no effect on any cycle length or flag.
- R7: An integer ratio of 0 to 3 behaves exactly like a ratio of 4.
- R8: `long_cyc` is constant over a whole output cycle, including its closing pulse. It changes only at the boundary edge.
- R9: Ratios up to the 13-bit maximum of 8191 give cycles of 8191 or 8192 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided VCO clock being counted |
| rst | input | 1 | Synchronous reset, active high |
| ratio_int | input | 13 | Integer division ratio N |
| frac_num | input | 2 | Fraction numerator k (quarter steps) |
| div_pulse | output | 1 | One-clock pulse that closes each output cycle |
| long_cyc | output | 1 | 1 when the current cycle divides by N+1 |

## Verification
On every cycle the assertions check the following: the pulse is one clock wide, the modulus flag changes only at a boundary, a zero fraction never yields a long cycle, and the counter reload never drops below the clamped floor. The scenarios alone show that the measured pulse spacing matches an independent accumulator model over every fraction value. They also show that the clamp for small ratios and the 13-bit maximum give the expected lengths, that mid-cycle changes to the inputs are ignored, and that a reset in the middle of a cycle restarts cleanly.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_TERM  = 1'b1
    } fbdiv_state_e;

endpackage

// File: rtl/fbdiv_clamp.sv
module fbdiv_clamp #(
    parameter int NW        = 13,
    parameter int MIN_RATIO = 4
) (
    input  logic [NW-1:0] ratio_raw,
    output logic [NW-1:0] ratio_eff
);
    localparam logic [NW-1:0] FLOOR = NW'(MIN_RATIO);

    always_comb begin
        ratio_eff = (ratio_raw < FLOOR) ? FLOOR : ratio_raw;
    end
endmodule

// File: rtl/fbdiv_accum.sv
module fbdiv_accum #(
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [FW-1:0] frac,
    output logic          carry_next,
    output logic          long_q
);
    logic [FW-1:0] acc_q;
    logic [FW:0]   sum;

    always_comb begin
        sum        = {1'b0, acc_q} + {1'b0, frac};
        carry_next = sum[FW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            long_q <= 1'b0;
        end else if (step) begin
            acc_q  <= sum[FW-1:0];
            long_q <= sum[FW];
        end
    end

    // R5: a zero fraction can never produce a long cycle
    a_r5_zero_frac_short: assert property (@(posedge clk) disable iff (rst)
        (step && frac == '0) |=> !long_q);

    // R8: the modulus flag moves only on a boundary edge
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(long_q));
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter #(
    parameter int CW       = 13,
    parameter int MIN_LOAD = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] load_val,
    output logic          term
);
    import fbdiv_pkg::*;

    fbdiv_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_COUNT: begin
                if (cnt_q == '0) begin
                    state_d = ST_TERM;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_TERM: begin
                state_d = ST_COUNT;
                cnt_d   = load_val;
            end
            default: begin
                state_d = ST_COUNT;
                cnt_d   = load_val;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_COUNT;
            cnt_q   <= load_val;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        term = (state_q == ST_TERM);
    end

    // R2: the terminal state never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        term |=> !term);

    // R7: every reload respects the clamped floor
    a_r7_reload_floor: assert property (@(posedge clk) disable iff (rst)
        term |=> (cnt_q >= CW'(MIN_LOAD)));
endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider #(
    parameter int NW        = 13,
    parameter int FW        = 2,
    parameter int MIN_RATIO = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] ratio_int,
    input  logic [FW-1:0] frac_num,
    output logic          div_pulse,
    output logic          long_cyc
);
    localparam int MIN_LOAD = MIN_RATIO - 2;

    logic [NW-1:0] ratio_eff;
    logic          carry_next;
    logic          long_q;
    logic          term;
    logic [NW:0]   load_wide;
    logic [NW-1:0] load_val;

    fbdiv_clamp #(
        .NW        (NW),
        .MIN_RATIO (MIN_RATIO)
    ) u_clamp (
        .ratio_raw (ratio_int),
        .ratio_eff (ratio_eff)
    );

    fbdiv_accum #(
        .FW (FW)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .step       (term),
        .frac       (frac_num),
        .carry_next (carry_next),
        .long_q     (long_q)
    );

    // Reload value: next cycle length minus the reload and terminal clocks.
    always_comb begin
        load_wide = {1'b0, ratio_eff} + (NW+1)'(rst ? 1'b0 : carry_next)
                    - (NW+1)'(2);
        load_val  = load_wide[NW-1:0];
    end

    fbdiv_counter #(
        .CW       (NW),
        .MIN_LOAD (MIN_LOAD)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load_val (load_val),
        .term     (term)
    );

    always_comb begin
        div_pulse = term;
        long_cyc  = long_q;
    end

    // R1: the cycle after a reset edge shows no pulse and a short modulus
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!div_pulse && !long_cyc));
endmodule

// File: tb/test_frac_fb_divider.sv
module test_frac_fb_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] n_in = 13'd10;
    logic [1:0]  k_in = 2'd0;
    logic        div_pulse;
    logic        long_cyc;

    typedef struct {
        int len;
        bit lng;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    int    acc_m = 0;
    int    edge_cnt = 0;
    bit    mon_on = 1'b0;
    bit    prev_pulse = 1'b0;
    string scen = "R1 reset";

    always #5 clk = ~clk;

    frac_fb_divider i_frac_fb_divider (
        .clk       (clk),
        .rst       (rst),
        .ratio_int (n_in),
        .frac_num  (k_in),
        .div_pulse (div_pulse),
        .long_cyc  (long_cyc)
    );

    function automatic int eff(input int n);
        return (n < 4) ? 4 : n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
        end
    endtask

    // Monitor: counts edges, compares each closed cycle with the queue.
    always @(posedge clk) begin
        if (mon_on && !rst) edge_cnt++;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (div_pulse) begin
                check(!prev_pulse, "R2 pulse width", 1, 0);
                if (q.size() == 0) begin
                    check(1'b0, "R3 unexpected pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(edge_cnt == e.len, "R3 interval", edge_cnt, e.len);
                    check(long_cyc == e.lng, "R4 modulus flag", long_cyc, e.lng);
                end
                edge_cnt = 0;
            end else begin
                // R8: flag stays put between boundaries
                if (q.size() > 0) check(long_cyc == q[0].lng, "R8 flag hold", long_cyc, q[0].lng);
            end
            prev_pulse = div_pulse;
        end
    end

    task automatic do_reset(input int n, input int k);
        mon_on = 1'b0;
        rst    = 1'b1;
        n_in   = 13'(n);
        k_in   = 2'(k);
        q.delete();
        acc_m  = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        scen = "R1 reset";
        check(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
        check(long_cyc == 1'b0, "R1 flag in reset", long_cyc, 0);
        q.push_back('{len: eff(n) - 1, lng: 1'b0});
        edge_cnt   = 0;
        prev_pulse = 1'b0;
        rst        = 1'b0;
        mon_on     = 1'b1;
    endtask

    // Driver: at each pulse, predict the cycle that begins at the boundary.
    task automatic drive(input int n, input int k, input int cycles,
                         input bit glitch, input string tag);
        n_in = 13'(n);
        k_in = 2'(k);
        for (int c = 0; c < cycles; c++) begin
            int sum;
            do @(negedge clk); while (!div_pulse);
            scen = tag;
            sum   = acc_m + int'(k_in);
            acc_m = sum % 4;
            q.push_back('{len: eff(int'(n_in)) + sum / 4, lng: (sum >= 4)});
            if (glitch) begin
                @(negedge clk);
                n_in = 13'd3000;
                k_in = 2'd3;
                @(negedge clk);
                n_in = 13'(n);
                k_in = 2'(k);
            end else begin
                repeat (2) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset(10, 0);
        drive(10, 0, 6, 1'b0, "R5 k=0");
        drive(10, 1, 8, 1'b0, "R4 k=1");
        drive(7, 2, 8, 1'b0, "R4 k=2");
        drive(9, 3, 8, 1'b0, "R4 k=3");
        drive(2, 1, 6, 1'b0, "R7 clamp n=2");
        drive(0, 3, 5, 1'b0, "R7 clamp n=0");
        drive(4, 0, 4, 1'b0, "R7 n=4 boundary");
        drive(12, 1, 8, 1'b1, "R6 mid-cycle glitch");
        drive(8191, 3, 2, 1'b0, "R9 max ratio");
        drive(6, 2, 3, 1'b0, "R6 retune");
        repeat (3) @(negedge clk);
        do_reset(5, 2);
        drive(5, 2, 8, 1'b0, "R1 mid-cycle reset");
        while (q.size() > 0) @(negedge clk);
        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule